// File: doc/BRIEF.md
# Process Scheduling Queue Controller

This block holds the set of processes that are ready to run, together with the identity of the process the CPU is running now. Ready processes wait in a first-in first-out queue. A separate register holds the current process. The block carries out the default scheduling actions that apply when no software handler takes over, and the surrounding core issues them as commands. Four commands exist:

- **run** adds a process to the back of the queue.
- **wake** queues a process that a peripheral interrupt has made ready.
- **stop** drops the current process and starts the one at the front of the queue.
- **timeslice** puts the current process at the back of the queue and starts the front one.

When there is no current process, the block reports idle. While idle it waits until a process is scheduled, then starts that process directly.

Commands arrive on a valid/ready port, and at most one is accepted per clock. A command takes effect when `cmd_valid` and `cmd_ready` are both high at a rising edge. Its effect is visible on the outputs after that edge. The block asserts back-pressure only when the queue is full and the pending command is run or wake. Stop and timeslice never grow the queue, so they are always accepted. A source that sees `cmd_ready` low must hold its command until it is accepted.

Top module: `sched_queue_ctrl`

## Requirements
- R1: After reset, `idle` is 1, `q_count` is 0 and `q_full` is 0.
- R2: An accepted run (`cmd_op`=2'b00) or wake (`cmd_op`=2'b11) while busy appends `cmd_pid` to the back of the queue. `q_count` rises by one and `cur_pid` is unchanged.
- R3: An accepted run or wake while idle makes `cmd_pid` the current process on the next cycle. `idle` drops and `q_count` stays 0.
- R4: An accepted stop (`cmd_op`=2'b01) while busy with a non-empty queue makes the front entry current, in the order the entries were queued, and lowers `q_count` by one.
- R5: A stop while busy with an empty queue raises `idle`. A stop while idle changes nothing.
- R6: An accepted timeslice (`cmd_op`=2'b10) with `slice_due`=1, while busy with a non-empty queue, puts the current process at the back of the queue and makes the front entry current. `q_count` is unchanged, and this holds even when the queue is full.
- R7: A timeslice with `slice_due`=0, or with an empty queue, or while idle, leaves `cur_pid`, `idle` and `q_count` unchanged.
- R8: `q_full` is high exactly when the queue holds 16 entries. While it is high, `cmd_ready` is low for run and wake and high for stop and timeslice.
- R9: A command with `cmd_valid` low, or one refused with `cmd_ready` low, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 00 run, 01 stop, 10 timeslice, 11 wake |
| cmd_pid | input | 8 | Process identifier for run and wake |
| slice_due | input | 1 | A timeslice is due and enabled |
| idle | output | 1 | No current process exists |
| cur_pid | output | 8 | Current process, valid while idle is low |
| q_full | output | 1 | Queue holds its maximum number of entries |
| q_count | output | 5 | Number of queued processes |

## Verification
The hardest state to reach is a timeslice on a completely full queue. There the write at the tail lands in the slot being read at the head, in the same cycle. To get there, the stimulus first starts a process while idle and then queues sixteen more processes behind it. It checks the refused run at the full boundary, then issues the timeslice. The queue is then drained with stops, and the exact order of the current processes shows whether the wrapped entry survived.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    OP_RUN   = 2'b00,
    OP_STOP  = 2'b01,
    OP_SLICE = 2'b10,
    OP_WAKE  = 2'b11
  } sq_op_e;
endpackage

// File: rtl/sq_fifo.sv
module sq_fifo #(
  parameter int DEPTH = 16,
  parameter int PW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  input  logic          pop,
  output logic [PW-1:0] front,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= wrap_inc(tail);
      if (pop)  head <= wrap_inc(head);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_data;
  end

  assign front = mem[head];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/sq_decode.sv
module sq_decode
  import sq_pkg::*;
(
  input  sq_op_e op,
  input  logic   fire,
  input  logic   due,
  input  logic   idle,
  input  logic   empty,
  output logic   push,
  output logic   push_cur,
  output logic   pop,
  output logic   load_cmd,
  output logic   load_front,
  output logic   go_idle
);
  always_comb begin
    push       = 1'b0;
    push_cur   = 1'b0;
    pop        = 1'b0;
    load_cmd   = 1'b0;
    load_front = 1'b0;
    go_idle    = 1'b0;
    if (fire) begin
      unique case (op)
        OP_RUN, OP_WAKE: begin
          if (idle) load_cmd = 1'b1;
          else      push     = 1'b1;
        end
        OP_STOP: begin
          if (!idle) begin
            if (empty) go_idle = 1'b1;
            else begin
              pop        = 1'b1;
              load_front = 1'b1;
            end
          end
        end
        OP_SLICE: begin
          if (!idle && due && !empty) begin
            push       = 1'b1;
            push_cur   = 1'b1;
            pop        = 1'b1;
            load_front = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sched_queue_ctrl.sv
module sched_queue_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [PW-1:0] cmd_pid,
  input  logic          slice_due,
  output logic          idle,
  output logic [PW-1:0] cur_pid,
  output logic          q_full,
  output logic [CW-1:0] q_count
);
  sq_op_e        op;
  logic          fire, q_empty;
  logic          push, push_cur, pop, load_cmd, load_front, go_idle;
  logic [PW-1:0] front, push_data;

  assign op        = sq_op_e'(cmd_op);
  assign cmd_ready = !(q_full && (op == OP_RUN || op == OP_WAKE));
  assign fire      = cmd_valid && cmd_ready;
  assign push_data = push_cur ? cur_pid : cmd_pid;

  sq_decode u_dec (
    .op(op), .fire(fire), .due(slice_due), .idle(idle), .empty(q_empty),
    .push(push), .push_cur(push_cur), .pop(pop),
    .load_cmd(load_cmd), .load_front(load_front), .go_idle(go_idle)
  );

  sq_fifo #(.DEPTH(DEPTH), .PW(PW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .front(front), .empty(q_empty), .full(q_full), .count(q_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle    <= 1'b1;
      cur_pid <= '0;
    end else begin
      if (load_cmd) begin
        cur_pid <= cmd_pid;
        idle    <= 1'b0;
      end else if (load_front) begin
        cur_pid <= front;
      end else if (go_idle) begin
        idle    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [PW-1:0] cmd_pid,
  input logic          slice_due,
  input logic          idle,
  input logic [PW-1:0] cur_pid,
  input logic          q_full,
  input logic [CW-1:0] q_count
);
  // R3
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> q_count == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && cmd_op[0] == cmd_op[1]) |-> !cmd_ready);

  // R3
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && idle && cmd_op[0] == cmd_op[1]) |=>
      (!idle && cur_pid == $past(cmd_pid)));

  // R5
  stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !idle && q_count == '0 && cmd_op == 2'b01) |=> idle);

  // R7
  slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10 && !slice_due) |=>
      ($stable(cur_pid) && $stable(q_count) && $stable(idle)));

  // R9
  no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(cur_pid) && $stable(q_count) && $stable(idle)));
endmodule

bind sched_queue_ctrl sq_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_pid(cmd_pid), .slice_due(slice_due), .idle(idle),
  .cur_pid(cur_pid), .q_full(q_full), .q_count(q_count)
);

// File: tb/sim_sched_queue_ctrl.sv
`timescale 1ns/1ps
module sim_sched_queue_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_pid = 8'h00;
  logic       slice_due = 1'b0;
  logic       idle;
  logic [7:0] cur_pid;
  logic       q_full;
  logic [4:0] q_count;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sched_queue_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pid(cmd_pid), .slice_due(slice_due), .idle(idle),
    .cur_pid(cur_pid), .q_full(q_full), .q_count(q_count)
  );

  // vector: req(4) op(2) pid(8) due(1) exp_idle(1) exp_cur(8) exp_cnt(5)
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {4'd3, 2'b00, 8'h11, 1'b0, 1'b0, 8'h11, 5'd0},
    {4'd2, 2'b00, 8'h22, 1'b0, 1'b0, 8'h11, 5'd1},
    {4'd2, 2'b11, 8'h33, 1'b0, 1'b0, 8'h11, 5'd2},
    {4'd7, 2'b10, 8'h00, 1'b0, 1'b0, 8'h11, 5'd2},
    {4'd6, 2'b10, 8'h00, 1'b1, 1'b0, 8'h22, 5'd2},
    {4'd4, 2'b01, 8'h00, 1'b0, 1'b0, 8'h33, 5'd1},
    {4'd4, 2'b01, 8'h00, 1'b0, 1'b0, 8'h11, 5'd0},
    {4'd7, 2'b10, 8'h00, 1'b1, 1'b0, 8'h11, 5'd0},
    {4'd5, 2'b01, 8'h00, 1'b0, 1'b1, 8'h00, 5'd0},
    {4'd5, 2'b01, 8'h00, 1'b0, 1'b1, 8'h00, 5'd0},
    {4'd3, 2'b11, 8'h44, 1'b0, 1'b0, 8'h44, 5'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, sampled at following negedge
  task automatic issue(input logic [1:0] op, input logic [7:0] pid, input logic due);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pid = pid; slice_due = due;
    @(negedge clk);
    cmd_valid = 1'b0; slice_due = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "idle", idle, 1);
    chk("R1", "count", q_count, 0);
    chk("R1", "full", q_full, 0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VEC[i][28:25]);
      issue(VEC[i][24:23], VEC[i][22:15], VEC[i][14]);
      chk(r, $sformatf("vec%0d idle", i), idle, VEC[i][13]);
      if (!VEC[i][13]) chk(r, $sformatf("vec%0d cur", i), cur_pid, VEC[i][12:5]);
      chk(r, $sformatf("vec%0d count", i), q_count, VEC[i][4:0]);
    end

    // R9: no valid, no effect
    @(negedge clk);
    cmd_op = 2'b00; cmd_pid = 8'hEE;
    @(negedge clk);
    chk("R9", "count idle cmd", q_count, 0);
    chk("R9", "cur idle cmd", cur_pid, 8'h44);

    // R2 / R8: fill to 16
    for (int i = 0; i < 16; i++) issue(2'b00, 8'h50 + 8'(i), 1'b0);
    chk("R2", "count filled", q_count, 16);
    chk("R8", "full", q_full, 1);
    chk("R2", "cur unchanged", cur_pid, 8'h44);

    // R8: run refused while full, stop/slice ready
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_pid = 8'hAA;
    #0.5;
    chk("R8", "ready run full", cmd_ready, 0);
    cmd_op = 2'b11;
    #0.5;
    chk("R8", "ready wake full", cmd_ready, 0);
    @(negedge clk);
    chk("R9", "count after refused", q_count, 16);
    chk("R9", "cur after refused", cur_pid, 8'h44);
    cmd_valid = 1'b0;
    cmd_op = 2'b01;
    #0.5;
    chk("R8", "ready stop full", cmd_ready, 1);
    cmd_op = 2'b10;
    #0.5;
    chk("R8", "ready slice full", cmd_ready, 1);

    // R6: timeslice on full queue
    issue(2'b10, 8'h00, 1'b1);
    chk("R6", "cur after full slice", cur_pid, 8'h50);
    chk("R6", "count after full slice", q_count, 16);

    // R4: drain in order 51..5F then 44
    for (int i = 0; i < 16; i++) begin
      issue(2'b01, 8'h00, 1'b0);
      chk("R4", $sformatf("drain %0d cur", i), cur_pid, (i < 15) ? 8'h51 + i : 8'h44);
      chk("R4", $sformatf("drain %0d count", i), q_count, 15 - i);
    end
    chk("R8", "not full after drain", q_full, 0);
    issue(2'b01, 8'h00, 1'b0);
    chk("R5", "idle after last stop", idle, 1);
    // R7: timeslice while idle ignored
    issue(2'b10, 8'h00, 1'b1);
    chk("R7", "slice idle", idle, 1);
    chk("R7", "slice idle count", q_count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule